// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block carries out the hardware side of taking an exception. A request brings an 8-bit vector, a flag saying whether the cause came from outside the processor, and a selector-style error code, together with a snapshot of the interrupted context. The block presents the vector on a gate lookup port and reads the answer one cycle later. The answer says whether the gate exists, whether it is 16 or 32 bits wide, the handler's privilege level, the handler CS:EIP and the stack to switch to.

When the gate is missing, the block re-raises the event as a general-protection exception with a generated error code. A second missing gate escalates to a double fault, and a third one halts the sequencer in shutdown. Once a gate is found, the block works out the vector's class and whether an error code belongs in the frame, and whether the privilege change forces a stack switch. It then pushes the frame one word at a time through a valid/ready write port. The frame ends with a one-cycle completion pulse that carries the handler entry point and the final stack pointer.

Top module: `exc_frame_seq`

## Requirements
- R1: `done_class` reports the class of the serviced vector: 0 fault (0x00, 0x05-0x07, 0x0B-0x0E, 0x10, 0x11, 0x13), 1 trap (0x02-0x04), 2 abort (0x08, 0x12), 3 reserved (0x09, 0x0F, 0x14-0x1F), 4 user (0x20 and up). Vector 0x01 is a fault when `req_alt`=1 and a trap otherwise. Vector 0x0A is an abort when `req_alt`=1 and a fault otherwise.
- R2: An error code is the last word of the frame only when the serviced vector is 0x08, 0x0A, 0x0B, 0x0C, 0x0D or 0x0E. For any other vector the frame ends with the saved EIP.
- R3: When `gate_dpl` differs from `cur_cpl`, the frame goes onto the gate's stack (`gate_ss`/`gate_esp`) and begins with the old SS and old ESP. Otherwise it goes onto the current stack without them.
- R4: Words are written in the order old SS, old ESP (switch only), EFLAGS, CS, saved EIP, error code. `done_esp` equals the address of the last word written.
- R5: A 32-bit gate lowers the stack pointer by 4 before each write and writes full words. A 16-bit gate lowers it by 2 and writes only the low 16 bits, with the upper bits zero.
- R6: A missing gate for any vector other than 0x08 and 0x0D is replaced by vector 0x0D. The error code then has bit 0 = `req_ext`, bit 1 = 1, bit 2 = 0 and bits 15:3 = the original vector.
- R7: A missing gate for vector 0x0D is replaced by vector 0x08 with error code 0. A missing gate for 0x08 raises `shutdown`, which stays high until reset with no further writes or completions.
- R8: The saved EIP is `next_eip` for traps and user vectors, and `cur_eip` for all other classes.
- R9: At most one word is written per cycle. While `mem_wvalid` is high and `mem_wready` is low, the address and data hold steady.
- R10: `done` pulses for one cycle with the serviced vector and the handler CS, EIP and SS. Requests presented while `busy` is high are ignored.
- R11: After reset the block is idle, with `busy`, `mem_wvalid`, `done` and `shutdown` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request, taken when not busy |
| req_vector | input | 8 | Requested vector |
| req_ext | input | 1 | Cause was external to the processor |
| req_alt | input | 1 | Picks fault (0x01) or abort (0x0A) variant |
| req_err | input | 16 | Error code supplied with the request |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack segment |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Flags to save |
| cur_cs | input | 16 | Code segment to save |
| cur_eip | input | 32 | Address of the causing instruction |
| next_eip | input | 32 | Address of the following instruction |
| busy | output | 1 | Entry in progress |
| gate_vector | output | 8 | Vector whose gate is being looked up |
| gate_present | input | 1 | Gate for `gate_vector` exists |
| gate_is32 | input | 1 | Gate is 32-bit (0: 16-bit) |
| gate_dpl | input | 2 | Handler code privilege level |
| gate_cs | input | 16 | Handler code segment |
| gate_eip | input | 32 | Handler entry offset |
| gate_ss | input | 16 | Stack segment used on a switch |
| gate_esp | input | 32 | Stack pointer used on a switch |
| mem_wvalid | output | 1 | Stack write valid |
| mem_wready | input | 1 | Stack write accepted |
| mem_waddr | output | 32 | Stack write offset |
| mem_wdata | output | 32 | Stack write data |
| mem_wsize32 | output | 1 | 1: 32-bit word, 0: 16-bit word |
| done | output | 1 | Entry complete pulse |
| done_vector | output | 8 | Vector finally serviced |
| done_class | output | 3 | Class code of that vector |
| done_cs | output | 16 | Handler code segment |
| done_eip | output | 32 | Handler entry offset |
| done_ss | output | 16 | Stack segment in use |
| done_esp | output | 32 | Final stack pointer |
| shutdown | output | 1 | Unrecoverable triple miss |

## Verification
The assertions assume that the gate inputs are a steady function of `gate_vector` during the lookup cycle. They also assume that `mem_wready` only answers a raised `mem_wvalid`. The bench meets both conditions by driving the gate fields combinationally from a fixed table indexed by `gate_vector`, and by toggling `mem_wready` randomly on falling edges. Some gates in the table are absent, so the escalation path is exercised. Directed cases remove the general-protection and double-fault gates, and hold `req_valid` high during a busy entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 8;
  localparam int SEL_W = 16;
  localparam int DATA_W = 32;
  localparam logic [VEC_W-1:0] VEC_DF = 8'h08;
  localparam logic [VEC_W-1:0] VEC_GP = 8'h0D;
  localparam logic [2:0] IX_SS  = 3'd0;
  localparam logic [2:0] IX_SP  = 3'd1;
  localparam logic [2:0] IX_FLG = 3'd2;
  localparam logic [2:0] IX_CS  = 3'd3;
  localparam logic [2:0] IX_IP  = 3'd4;
  localparam logic [2:0] IX_ERR = 3'd5;

  typedef enum logic [2:0] {
    CL_FAULT = 3'd0, CL_TRAP = 3'd1, CL_ABORT = 3'd2, CL_RSVD = 3'd3, CL_USER = 3'd4
  } exc_class_e;

  typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_PUSH, ST_HALT} seq_state_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic [VW-1:0] vec,
  input  logic          alt,
  output exc_class_e    cls,
  output logic          has_err,
  output logic          saves_next
);
  logic hi;
  assign hi = |vec[VW-1:5];

  always_comb begin
    cls = CL_RSVD;
    if (hi) cls = CL_USER;
    else begin
      case (vec[4:0])
        5'h00, 5'h05, 5'h06, 5'h07, 5'h0B, 5'h0C, 5'h0D, 5'h0E,
        5'h10, 5'h11, 5'h13: cls = CL_FAULT;
        5'h02, 5'h03, 5'h04: cls = CL_TRAP;
        5'h08, 5'h12:        cls = CL_ABORT;
        5'h01:               cls = alt ? CL_FAULT : CL_TRAP;
        5'h0A:               cls = alt ? CL_ABORT : CL_FAULT;
        default:             cls = CL_RSVD;
      endcase
    end
  end

  always_comb begin
    has_err = 1'b0;
    if (!hi) begin
      case (vec[4:0])
        5'h08, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E: has_err = 1'b1;
        default: has_err = 1'b0;
      endcase
    end
  end

  assign saves_next = (cls == CL_TRAP) || (cls == CL_USER);
endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word
  import exc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic [2:0]    sel,
  input  logic          w32,
  input  logic [SW-1:0] ss,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] flags,
  input  logic [SW-1:0] cs,
  input  logic [DW-1:0] ip,
  input  logic [SW-1:0] err,
  output logic [DW-1:0] word
);
  localparam int HW = DW / 2;
  logic [DW-1:0] raw;

  always_comb begin
    case (sel)
      IX_SS:   raw = DW'(ss);
      IX_SP:   raw = sp;
      IX_FLG:  raw = flags;
      IX_CS:   raw = DW'(cs);
      IX_IP:   raw = ip;
      default: raw = DW'(err);
    endcase
  end

  generate
    if (DW > HW) begin : g_mask
      assign word = w32 ? raw : {{(DW-HW){1'b0}}, raw[HW-1:0]};
    end else begin : g_full
      assign word = raw;
    end
  endgenerate
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int SW = SEL_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  input  logic          req_ext,
  input  logic          req_alt,
  input  logic [SW-1:0] req_err,
  input  logic [1:0]    cur_cpl,
  input  logic [SW-1:0] cur_ss,
  input  logic [DW-1:0] cur_esp,
  input  logic [DW-1:0] cur_eflags,
  input  logic [SW-1:0] cur_cs,
  input  logic [DW-1:0] cur_eip,
  input  logic [DW-1:0] next_eip,
  output logic          busy,
  output logic [VW-1:0] gate_vector,
  input  logic          gate_present,
  input  logic          gate_is32,
  input  logic [1:0]    gate_dpl,
  input  logic [SW-1:0] gate_cs,
  input  logic [DW-1:0] gate_eip,
  input  logic [SW-1:0] gate_ss,
  input  logic [DW-1:0] gate_esp,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [DW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wsize32,
  output logic          done,
  output logic [VW-1:0] done_vector,
  output logic [2:0]    done_class,
  output logic [SW-1:0] done_cs,
  output logic [DW-1:0] done_eip,
  output logic [SW-1:0] done_ss,
  output logic [DW-1:0] done_esp,
  output logic          shutdown
);
  localparam logic [DW-1:0] STEP_W = DW'(4);
  localparam logic [DW-1:0] STEP_H = DW'(2);

  seq_state_e    st;
  logic [VW-1:0] vec_q;
  logic          alt_q, ext_q, w32_q;
  logic [SW-1:0] err_q, ss_q, cs_q;
  logic [1:0]    cpl_q;
  logic [DW-1:0] esp_q, flg_q, eip_q, neip_q, ipsel_q, sp_q;
  logic [2:0]    idx_q, last_q;
  exc_class_e    cls_q;

  exc_class_e    cls;
  logic          has_err, saves_next;
  logic          sw_need;
  logic [DW-1:0] ip_pick, base_sp, sp_first, sp_next, word;
  logic [2:0]    first_idx, sel;

  exc_classify #(.VW(VW)) u_cls (
    .vec(vec_q), .alt(alt_q), .cls(cls), .has_err(has_err), .saves_next(saves_next)
  );

  assign sw_need   = (gate_dpl != cpl_q);
  assign ip_pick   = saves_next ? neip_q : eip_q;
  assign base_sp   = sw_need ? gate_esp : esp_q;
  assign sp_first  = base_sp - (gate_is32 ? STEP_W : STEP_H);
  assign sp_next   = sp_q - (w32_q ? STEP_W : STEP_H);
  assign first_idx = sw_need ? IX_SS : IX_FLG;
  assign sel       = (st == ST_GATE) ? first_idx : idx_q + 3'd1;

  exc_frame_word #(.DW(DW), .SW(SW)) u_word (
    .sel(sel), .w32((st == ST_GATE) ? gate_is32 : w32_q),
    .ss(ss_q), .sp(esp_q), .flags(flg_q), .cs(cs_q),
    .ip((st == ST_GATE) ? ip_pick : ipsel_q), .err(err_q), .word(word)
  );

  assign busy        = (st != ST_IDLE);
  assign gate_vector = vec_q;
  assign done_class  = cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; vec_q <= '0; alt_q <= 1'b0; ext_q <= 1'b0; w32_q <= 1'b0;
      err_q <= '0; ss_q <= '0; cs_q <= '0; cpl_q <= '0; esp_q <= '0; flg_q <= '0;
      eip_q <= '0; neip_q <= '0; ipsel_q <= '0; sp_q <= '0; idx_q <= '0; last_q <= '0;
      cls_q <= CL_FAULT; mem_wvalid <= 1'b0; mem_waddr <= '0; mem_wdata <= '0;
      mem_wsize32 <= 1'b0; done <= 1'b0; done_vector <= '0; done_cs <= '0;
      done_eip <= '0; done_ss <= '0; done_esp <= '0; shutdown <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          st <= ST_GATE; vec_q <= req_vector; alt_q <= req_alt; ext_q <= req_ext;
          err_q <= req_err; cpl_q <= cur_cpl; ss_q <= cur_ss; esp_q <= cur_esp;
          flg_q <= cur_eflags; cs_q <= cur_cs; eip_q <= cur_eip; neip_q <= next_eip;
        end
        ST_GATE: begin
          if (gate_present) begin
            st <= ST_PUSH; w32_q <= gate_is32; idx_q <= first_idx;
            last_q <= has_err ? IX_ERR : IX_IP; sp_q <= sp_first;
            ipsel_q <= ip_pick; cls_q <= cls;
            mem_wvalid <= 1'b1; mem_waddr <= sp_first; mem_wdata <= word;
            mem_wsize32 <= gate_is32;
            done_vector <= vec_q; done_cs <= gate_cs; done_eip <= gate_eip;
            done_ss <= sw_need ? gate_ss : ss_q;
          end else if (vec_q == VEC_DF) begin
            st <= ST_HALT; shutdown <= 1'b1;
          end else if (vec_q == VEC_GP) begin
            vec_q <= VEC_DF; err_q <= '0; alt_q <= 1'b0;
          end else begin
            vec_q <= VEC_GP; alt_q <= 1'b0;
            err_q <= SW'({vec_q, 1'b0, 1'b1, ext_q});
          end
        end
        ST_PUSH: if (mem_wvalid && mem_wready) begin
          if (idx_q == last_q) begin
            mem_wvalid <= 1'b0; done <= 1'b1; done_esp <= sp_q; st <= ST_IDLE;
          end else begin
            idx_q <= sel; sp_q <= sp_next; mem_waddr <= sp_next; mem_wdata <= word;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_wvalid,
  input logic          mem_wready,
  input logic [DW-1:0] mem_waddr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wsize32,
  input logic          done,
  input logic [DW-1:0] done_esp,
  input logic          shutdown
);
  localparam int HW = DW / 2;
  logic          have_prev;
  logic [DW-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0; prev_addr <= '0;
    end else if (done) begin
      have_prev <= 1'b0;
    end else if (mem_wvalid && mem_wready) begin
      have_prev <= 1'b1; prev_addr <= mem_waddr;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_final_sp_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> done_esp == prev_addr);
  assert_half_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wvalid && !mem_wsize32 |-> mem_wdata[DW-1:HW] == '0);
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wvalid && have_prev |-> mem_waddr == prev_addr - (mem_wsize32 ? DW'(4) : DW'(2)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst) shutdown |=> shutdown);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> !mem_wvalid && !done);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
  .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wsize32(mem_wsize32),
  .done(done), .done_esp(done_esp), .shutdown(shutdown)
);

// File: tb/tb_exc_frame_seq.sv
module tb_exc_frame_seq;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ext = 0, req_alt = 0;
  logic [7:0] req_vector = 0;
  logic [15:0] req_err = 0, cur_ss = 0, cur_cs = 0;
  logic [1:0] cur_cpl = 0;
  logic [31:0] cur_esp = 0, cur_eflags = 0, cur_eip = 0, next_eip = 0;
  logic busy, gate_present, gate_is32, mem_wvalid, mem_wsize32, done, shutdown;
  logic [7:0] gate_vector, done_vector;
  logic [1:0] gate_dpl;
  logic [15:0] gate_cs, gate_ss, done_cs, done_ss;
  logic [31:0] gate_eip, gate_esp, mem_waddr, mem_wdata, done_eip, done_esp;
  logic [2:0] done_class;
  logic mem_wready = 1;

  logic tp [256]; logic t32 [256]; logic [1:0] tdpl [256];
  logic [15:0] tcs [256]; logic [15:0] tss [256];
  logic [31:0] teip [256]; logic [31:0] tesp [256];
  assign gate_present = tp[gate_vector];
  assign gate_is32 = t32[gate_vector];
  assign gate_dpl = tdpl[gate_vector];
  assign gate_cs = tcs[gate_vector];
  assign gate_eip = teip[gate_vector];
  assign gate_ss = tss[gate_vector];
  assign gate_esp = tesp[gate_vector];

  exc_frame_seq dut (.*);

  int nchk = 0, nfail = 0, cycles = 0;
  logic clr = 0, rnd_ready = 0;
  int nwr = 0;
  logic [31:0] wa [8]; logic [31:0] wd [8];

  always @(posedge clk) begin
    if (clr) nwr <= 0;
    else if (mem_wvalid && mem_wready && nwr < 8) begin
      wa[nwr] <= mem_waddr; wd[nwr] <= mem_wdata; nwr <= nwr + 1;
    end
  end
  always @(negedge clk) mem_wready <= rnd_ready ? (($urandom % 4) != 0) : 1'b1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // Independent reference model
  function automatic logic [2:0] ref_class(input logic [7:0] v, input logic a);
    if (v >= 8'h20) return 3'd4;
    if (v == 8'h01) return a ? 3'd0 : 3'd1;
    if (v == 8'h0A) return a ? 3'd2 : 3'd0;
    if (v == 8'h02 || v == 8'h03 || v == 8'h04) return 3'd1;
    if (v == 8'h08 || v == 8'h12) return 3'd2;
    if (v == 8'h09 || v == 8'h0F || v >= 8'h14) return 3'd3;
    return 3'd0;
  endfunction

  function automatic bit ref_err(input logic [7:0] v);
    return v == 8'h08 || v == 8'h0A || v == 8'h0B || v == 8'h0C || v == 8'h0D || v == 8'h0E;
  endfunction

  task automatic run_one(input logic [7:0] v, input bit hold_extra, input string tag);
    logic [7:0] ev; logic [15:0] ee; logic ea; bit shut; logic [2:0] ec;
    logic [31:0] sp, step, ipv; logic [31:0] items [6]; logic [31:0] ea_a [6]; logic [31:0] ed_a [6];
    int ne, cyc; bit sw; bit w;
    ev = v; ee = req_err; ea = req_alt; shut = 0;
    for (int k = 0; k < 3; k++) begin
      if (tp[ev] || shut) break;
      if (ev == 8'h08) shut = 1;
      else if (ev == 8'h0D) begin ev = 8'h08; ee = 16'h0; ea = 0; end
      else begin ee = {5'b0, ev, 1'b0, 1'b1, req_ext}; ev = 8'h0D; ea = 0; end
    end
    ec = ref_class(ev, ea);
    w = t32[ev]; sw = (tdpl[ev] != cur_cpl);
    ipv = (ec == 3'd1 || ec == 3'd4) ? next_eip : cur_eip;
    items[0] = {16'h0, cur_ss}; items[1] = cur_esp; items[2] = cur_eflags;
    items[3] = {16'h0, cur_cs}; items[4] = ipv; items[5] = {16'h0, ee};
    sp = sw ? tesp[ev] : cur_esp; step = w ? 4 : 2; ne = 0;
    for (int i = (sw ? 0 : 2); i <= (ref_err(ev) ? 5 : 4); i++) begin
      sp = sp - step; ea_a[ne] = sp; ed_a[ne] = w ? items[i] : {16'h0, items[i][15:0]}; ne++;
    end

    @(negedge clk); clr = 1; req_vector = v; req_valid = 1;
    @(negedge clk); clr = 0;
    if (hold_extra) begin
      req_vector = v ^ 8'h21; @(negedge clk); @(negedge clk);
    end
    req_valid = 0;
    cyc = 0;
    while (!done && !shutdown && cyc < 400) begin @(negedge clk); cyc++; end

    if (shut) begin
      chk(shutdown == 1, {"R7 shutdown ", tag}, 32'(shutdown), 1);
      chk(nwr == 0, {"R7 no writes ", tag}, nwr, 0);
      chk(busy == 1, {"R7 busy ", tag}, 32'(busy), 1);
      return;
    end
    chk(done == 1, {"R10 done ", tag}, 32'(done), 1);
    chk(done_vector == ev, {"R6 R7 vector ", tag}, 32'(done_vector), 32'(ev));
    chk(done_class == ec, {"R1 class ", tag}, 32'(done_class), 32'(ec));
    chk(nwr == ne, {"R2 R3 word count ", tag}, nwr, ne);
    for (int i = 0; i < ne && i < nwr; i++) begin
      chk(wa[i] == ea_a[i], {"R5 address ", tag}, wa[i], ea_a[i]);
      chk(wd[i] == ed_a[i], {"R4 R8 data ", tag}, wd[i], ed_a[i]);
    end
    chk(done_esp == sp, {"R4 final sp ", tag}, done_esp, sp);
    chk(done_cs == tcs[ev] && done_eip == teip[ev], {"R10 handler ", tag}, done_eip, teip[ev]);
    chk(done_ss == (sw ? tss[ev] : cur_ss), {"R3 ss ", tag}, 32'(done_ss), 32'(sw ? tss[ev] : cur_ss));
    @(negedge clk);
    chk(done == 0, {"R10 pulse ", tag}, 32'(done), 0);
  endtask

  task automatic set_ctx();
    req_ext = 1'($urandom); req_alt = 1'($urandom); req_err = 16'($urandom);
    cur_cpl = 2'($urandom); cur_ss = 16'($urandom); cur_esp = $urandom | 32'h100;
    cur_eflags = $urandom; cur_cs = 16'($urandom); cur_eip = $urandom; next_eip = $urandom;
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0104));
    for (int i = 0; i < 256; i++) begin
      tp[i] = ($urandom % 8) != 0; t32[i] = 1'($urandom); tdpl[i] = 2'($urandom);
      tcs[i] = 16'($urandom); tss[i] = 16'($urandom);
      teip[i] = $urandom; tesp[i] = $urandom | 32'h100;
    end
    tp[8'h0D] = 1; tp[8'h08] = 1;
    do_reset();
    @(negedge clk);
    chk(busy == 0 && mem_wvalid == 0 && done == 0 && shutdown == 0, "R11 reset idle",
        {busy, mem_wvalid, done, shutdown}, 0);

    // Directed: same-privilege trap, 32-bit, no error code
    set_ctx(); tdpl[3] = cur_cpl; t32[3] = 1; tp[3] = 1;
    run_one(8'h03, 0, "trap32 same");
    // Directed: stack switch, 16-bit, error code vector
    set_ctx(); tdpl[8'h0E] = ~cur_cpl; t32[8'h0E] = 0; tp[8'h0E] = 1;
    run_one(8'h0E, 0, "pf16 switch");
    // Directed: vector 0x01 both variants, 0x0A both variants
    set_ctx(); req_alt = 1; tp[1] = 1; run_one(8'h01, 0, "dbg fault");
    set_ctx(); req_alt = 0; run_one(8'h01, 0, "dbg trap");
    set_ctx(); req_alt = 1; tp[8'h0A] = 1; run_one(8'h0A, 0, "tss abort");
    set_ctx(); req_alt = 0; run_one(8'h0A, 0, "tss fault");
    // Directed: missing gate escalates to GP (R6)
    set_ctx(); tp[8'h05] = 0; run_one(8'h05, 0, "missing to gp");
    // Directed: requests while busy ignored (R10)
    set_ctx(); rnd_ready = 1; tp[8'h40] = 1; tp[8'h61] = 1; run_one(8'h40, 1, "busy hold");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      set_ctx(); run_one(8'($urandom), 0, "random");
    end
    rnd_ready = 0;

    // GP gate missing: escalate to double fault (R7)
    tp[8'h0D] = 0; tp[8'h22] = 0;
    set_ctx(); run_one(8'h22, 0, "gp missing to df");
    // Double fault also missing: shutdown (R7)
    tp[8'h08] = 0;
    set_ctx(); run_one(8'h22, 0, "triple miss");
    repeat (3) @(negedge clk);
    chk(shutdown == 1 && mem_wvalid == 0, "R7 shutdown sticky", 32'(shutdown), 1);
    do_reset(); @(negedge clk);
    chk(shutdown == 0 && busy == 0, "R11 reset after shutdown", 32'(shutdown), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule